// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a high-precision event timer. It holds a 64-bit configuration word, a 64-bit comparator, a 64-bit period and a 64-bit message-route word. It watches a free-running main counter that is supplied from outside. When the counter reaches the comparator value, the channel signals an interrupt. In periodic mode it then moves the comparator forward by the period.

An interrupt is delivered in one of three ways. It can go out on an interrupt line whose number comes from the configuration. In legacy mode the line number is remapped for channels 0 and 1. It can also go out as a single 32-bit message write. Software reaches the registers through a simple write port, which takes a register select, a 32-bit lane select and the data. It reads them back through a registered read port. A comparator write goes to the comparator, the period or both, depending on the periodic bit and a set-value bit that clears itself.

Top module: `etc_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads 0, the status, interrupt and message outputs are 0, and the low configuration word reads 0x8030 (periodic-capable bit 4, 64-bit-capable bit 5, message-capable bit 15 when MSG_CAP=1).
- R2: Writes to the comparator, period and route registers replace only the selected 32-bit lane (wr_hi=1 selects bits 63:32) and keep the other lane.
- R3: A comparator write (wr_sel=1) updates the comparator when periodic bit 3 is 0 or set-value bit 6 is 1. When periodic bit 3 is 1, it also updates the period.
- R4: Set-value bit 6 reads 0 after any comparator write.
- R5: Writing the low configuration word with bit 8 (32-bit mode) set clears the upper 32 bits of the comparator and the period. While bit 8 is set, comparator writes to the high lane are ignored, and matching and reload use only the low 32 bits.
- R6: A match occurs in the cycle the counter first equals the comparator. In periodic mode the comparator then becomes comparator plus period. With a period of 0 the comparator is kept.
- R7: A match delivers an interrupt only when channel enable bit 2 and glb_en are both 1. Otherwise irq_out, irq_sts and msg_req stay 0.
- R8: In edge mode (bit 1 = 0) a delivered match drives irq_out high for exactly one cycle, in the cycle after the matching counter value is sampled, and irq_sts is unchanged.
- R9: In level mode (bit 1 = 1) a delivered match sets irq_sts, and irq_out follows it. Both hold until sts_clr is 1, and both are 0 in the following cycle.
- R10: With message bit 14 set, a delivered match produces a one-cycle msg_req with msg_data equal to route bits 31:0 and msg_addr equal to route bits 63:32. irq_out stays 0.
- R11: irq_line equals configuration bits 13:9. With legacy_en=1, channel 0 reports line 0 and channel 1 reports line 8.
- R12: The high configuration word always reads LINE_MASK, and capability bits 4, 5 and 15 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 comparator, 2 route |
| wr_hi | input | 1 | Lane select: 1 = bits 63:32 |
| wr_data | input | 32 | Write data for the selected lane |
| rd_sel | input | 2 | Read source: 0 config, 1 comparator, 2 route, 3 period |
| rd_hi | input | 1 | Read lane select |
| rd_data | output | 32 | Registered read data |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy line remap for channels 0 and 1 |
| main_cnt | input | 64 | Free-running main counter |
| sts_clr | input | 1 | Clear the held level status |
| irq_line | output | 5 | Interrupt line number |
| irq_out | output | 1 | Interrupt line level or pulse |
| irq_sts | output | 1 | Channel interrupt status |
| msg_req | output | 1 | One-cycle message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume that only one register write happens per cycle, so a comparator write and a configuration write never coincide. They also assume the counter does not equal the comparator on two consecutive cycles unless it has stalled. The bench drives one write at a time. Before each match it returns the counter to 0, so every match is a fresh rising equality. Each sweep walks through edge, level, periodic, 32-bit and message modes in turn, and computes expected comparator and period values from the written lanes.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int REG_W   = 64;
  localparam int LANE_W  = 32;
  localparam int ROUTE_W = 5;

  localparam int B_LEVEL  = 1;
  localparam int B_EN     = 2;
  localparam int B_PER    = 3;
  localparam int B_PERCAP = 4;
  localparam int B_SZCAP  = 5;
  localparam int B_SETV   = 6;
  localparam int B_M32    = 8;
  localparam int B_RT_LO  = 9;
  localparam int B_MSGEN  = 14;
  localparam int B_MSGCAP = 15;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_ROUTE = 2'd2,
    SEL_PER   = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] put_lane(input logic [REG_W-1:0] v,
                                                input logic hi,
                                                input logic [LANE_W-1:0] d);
    logic [REG_W-1:0] r;
    r = v;
    if (hi) r[REG_W-1:LANE_W] = d;
    else    r[LANE_W-1:0]     = d;
    return r;
  endfunction
endpackage

// File: rtl/etc_cfg_regs.sv
module etc_cfg_regs
  import etc_pkg::*;
#(
  parameter logic [31:0] LINE_MASK = 32'h0000_0F04,
  parameter bit          MSG_CAP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_hi,
  input  logic [LANE_W-1:0] wr_data,
  output logic [REG_W-1:0]  cfg_q,
  output logic [REG_W-1:0]  route_q,
  output logic              trunc
);
  localparam logic [LANE_W-1:0] RST_LO =
    (LANE_W'(1) << B_PERCAP) | (LANE_W'(1) << B_SZCAP) |
    (LANE_W'(MSG_CAP) << B_MSGCAP);
  localparam logic [LANE_W-1:0] WMASK =
    (LANE_W'(1) << B_LEVEL) | (LANE_W'(1) << B_EN) | (LANE_W'(1) << B_PER) |
    (LANE_W'(1) << B_SETV) | (LANE_W'(1) << B_M32) |
    (LANE_W'((1 << ROUTE_W) - 1) << B_RT_LO) | (LANE_W'(MSG_CAP) << B_MSGEN);

  logic [LANE_W-1:0] cfg_lo;
  logic cfg_wr, cmp_wr, rt_wr;

  assign cfg_wr = wr_en && (wr_sel == SEL_CFG) && !wr_hi;
  assign cmp_wr = wr_en && (wr_sel == SEL_CMP);
  assign rt_wr  = wr_en && (wr_sel == SEL_ROUTE);
  assign trunc  = cfg_wr && wr_data[B_M32];
  assign cfg_q  = {LINE_MASK, cfg_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_lo  <= RST_LO;
      route_q <= '0;
    end else begin
      if (cfg_wr)
        cfg_lo <= (cfg_lo & ~WMASK) | (wr_data & WMASK);
      else if (cmp_wr)
        cfg_lo[B_SETV] <= 1'b0;
      if (rt_wr)
        route_q <= put_lane(route_q, wr_hi, wr_data);
    end
  end

  p_setval_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $past(cmp_wr) |-> !cfg_lo[B_SETV]);
  p_route_keep_lo_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rt_wr && wr_hi) |-> route_q[LANE_W-1:0] == $past(route_q[LANE_W-1:0]));
  p_caps_fixed_r12: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr) |-> (cfg_lo[B_PERCAP] && cfg_lo[B_SZCAP]));
endmodule

// File: rtl/etc_cmp_unit.sv
module etc_cmp_unit
  import etc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_hi,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              periodic,
  input  logic              setval,
  input  logic              m32,
  input  logic              trunc,
  input  logic [REG_W-1:0]  main_cnt,
  output logic [REG_W-1:0]  cmp_q,
  output logic [REG_W-1:0]  per_q,
  output logic              hit_rise
);
  logic hit, hit_q, cmp_wr, lane_ok;
  logic [REG_W-1:0] sum, reload_val, cmp_d, per_d;

  assign cmp_wr  = wr_en && (wr_sel == SEL_CMP);
  assign lane_ok = !(wr_hi && m32);

  always_comb begin
    if (m32) hit = (main_cnt[LANE_W-1:0] == cmp_q[LANE_W-1:0]);
    else     hit = (main_cnt == cmp_q);
  end
  assign hit_rise = hit && !hit_q;

  assign sum        = cmp_q + per_q;
  assign reload_val = m32 ? {{(REG_W-LANE_W){1'b0}}, sum[LANE_W-1:0]} : sum;

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (hit_rise && periodic && (per_q != '0))
      cmp_d = reload_val;
    if (cmp_wr && lane_ok) begin
      if (!periodic || setval) cmp_d = put_lane(cmp_q, wr_hi, wr_data);
      if (periodic)            per_d = put_lane(per_q, wr_hi, wr_data);
    end
    if (trunc) begin
      cmp_d[REG_W-1:LANE_W] = '0;
      per_d[REG_W-1:LANE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      per_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
      hit_q <= hit;
    end
  end

  p_trunc_r5: assert property (@(posedge clk) disable iff (rst)
    $past(trunc) |-> (cmp_q[REG_W-1:LANE_W] == '0 && per_q[REG_W-1:LANE_W] == '0));
  p_zero_period_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $past(hit_rise && per_q == '0 && !wr_en) |-> cmp_q == $past(cmp_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    $past(hit_rise && periodic && per_q != '0 && !wr_en && !m32)
      |-> cmp_q == $past(cmp_q) + $past(per_q));
  p_hi_lane_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    $past(cmp_wr && wr_hi && m32) |-> cmp_q[REG_W-1:LANE_W] == '0);
endmodule

// File: rtl/etc_irq_deliver.sv
module etc_irq_deliver
  import etc_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_rise,
  input  logic               ch_en,
  input  logic               glb_en,
  input  logic               level,
  input  logic               msg_en,
  input  logic               legacy_en,
  input  logic [ROUTE_W-1:0] route_fld,
  input  logic [REG_W-1:0]   route_q,
  input  logic               sts_clr,
  output logic [ROUTE_W-1:0] irq_line,
  output logic               irq_out,
  output logic               irq_sts,
  output logic               msg_req,
  output logic [LANE_W-1:0]  msg_addr,
  output logic [LANE_W-1:0]  msg_data
);
  logic fire, sts_d, out_d;
  logic [ROUTE_W-1:0] line_d;

  assign fire = hit_rise && ch_en && glb_en;

  always_comb begin
    if (fire && level) sts_d = 1'b1;
    else if (sts_clr)  sts_d = 1'b0;
    else               sts_d = irq_sts;
    if (msg_en)     out_d = 1'b0;
    else if (level) out_d = sts_d;
    else            out_d = fire;
  end

  generate
    if (CHAN_ID == 0) begin : g_leg0
      assign line_d = legacy_en ? ROUTE_W'(0) : route_fld;
    end else if (CHAN_ID == 1) begin : g_leg1
      assign line_d = legacy_en ? ROUTE_W'(8) : route_fld;
    end else begin : g_noleg
      assign line_d = route_fld;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sts  <= 1'b0;
      irq_out  <= 1'b0;
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
      irq_line <= '0;
    end else begin
      irq_sts  <= sts_d;
      irq_out  <= out_d;
      msg_req  <= fire && msg_en;
      irq_line <= line_d;
      if (fire && msg_en) begin
        msg_addr <= route_q[REG_W-1:LANE_W];
        msg_data <= route_q[LANE_W-1:0];
      end
    end
  end

  p_msg_no_line_r10: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> !irq_out);
  p_msg_single_r10: assert property (@(posedge clk) disable iff (rst)
    msg_req |=> !msg_req);
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sts) |-> $past(ch_en && glb_en));
  p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_sts && !sts_clr) |=> irq_sts);
  p_edge_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    $past(fire && !level && !msg_en) |-> irq_out);
endmodule

// File: rtl/etc_channel.sv
module etc_channel
  import etc_pkg::*;
#(
  parameter int          CHAN_ID   = 0,
  parameter logic [31:0] LINE_MASK = 32'h0000_0F04,
  parameter bit          MSG_CAP   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic         wr_hi,
  input  logic [31:0]  wr_data,
  input  logic [1:0]   rd_sel,
  input  logic         rd_hi,
  output logic [31:0]  rd_data,
  input  logic         glb_en,
  input  logic         legacy_en,
  input  logic [63:0]  main_cnt,
  input  logic         sts_clr,
  output logic [4:0]   irq_line,
  output logic         irq_out,
  output logic         irq_sts,
  output logic         msg_req,
  output logic [31:0]  msg_addr,
  output logic [31:0]  msg_data
);
  logic [REG_W-1:0] cfg_q, route_q, cmp_q, per_q, rd_src;
  logic trunc, hit_rise;

  etc_cfg_regs #(.LINE_MASK(LINE_MASK), .MSG_CAP(MSG_CAP)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
    .wr_data(wr_data), .cfg_q(cfg_q), .route_q(route_q), .trunc(trunc)
  );

  etc_cmp_unit u_cmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
    .wr_data(wr_data), .periodic(cfg_q[B_PER]), .setval(cfg_q[B_SETV]),
    .m32(cfg_q[B_M32]), .trunc(trunc), .main_cnt(main_cnt),
    .cmp_q(cmp_q), .per_q(per_q), .hit_rise(hit_rise)
  );

  etc_irq_deliver #(.CHAN_ID(CHAN_ID)) u_irq (
    .clk(clk), .rst(rst), .hit_rise(hit_rise), .ch_en(cfg_q[B_EN]),
    .glb_en(glb_en), .level(cfg_q[B_LEVEL]), .msg_en(cfg_q[B_MSGEN]),
    .legacy_en(legacy_en), .route_fld(cfg_q[B_RT_LO +: ROUTE_W]),
    .route_q(route_q), .sts_clr(sts_clr), .irq_line(irq_line),
    .irq_out(irq_out), .irq_sts(irq_sts), .msg_req(msg_req),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb begin
    case (rd_sel)
      SEL_CFG:   rd_src = cfg_q;
      SEL_CMP:   rd_src = cmp_q;
      SEL_ROUTE: rd_src = route_q;
      default:   rd_src = per_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_hi ? rd_src[REG_W-1:LANE_W] : rd_src[LANE_W-1:0];
  end

  p_reset_cmp_r1: assert property (@(posedge clk)
    $past(rst) |-> (cmp_q == '1 && per_q == '0 && !irq_sts && !msg_req));
endmodule

// File: tb/test_etc_channel.sv
module test_etc_channel;
  localparam logic [31:0] MASK = 32'h0000_0F04;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_hi = 0, rd_hi = 0, glb_en = 0, legacy_en = 0, sts_clr = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data, msg_addr, msg_data;
  logic [63:0] main_cnt = 0;
  logic [4:0] irq_line;
  logic irq_out, irq_sts, msg_req;
  int n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  etc_channel #(.CHAN_ID(1), .LINE_MASK(MASK), .MSG_CAP(1'b1)) i_etc_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data),
    .glb_en(glb_en), .legacy_en(legacy_en), .main_cnt(main_cnt),
    .sts_clr(sts_clr), .irq_line(irq_line), .irq_out(irq_out),
    .irq_sts(irq_sts), .msg_req(msg_req), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic h, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_hi = h; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic h, output logic [31:0] d);
    rd_sel = s; rd_hi = h;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic hit_at(input logic [63:0] c);
    main_cnt = 0;
    @(negedge clk);
    main_cnt = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(0, 0, v); check("R1 cfg lo", v, 32'h8030);
    rd(1, 0, v); check("R1 cmp lo", v, 32'hFFFF_FFFF);
    rd(1, 1, v); check("R1 cmp hi", v, 32'hFFFF_FFFF);
    rd(3, 0, v); check("R1 per lo", v, 0);
    check("R1 outputs", {irq_out, irq_sts, msg_req}, 0);
    // R12 read-only parts
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, v); check("R12 cfg hi", v, MASK);
    wr(0, 0, 32'h0);         rd(0, 0, v); check("R12 caps", v, 32'h8030);
    // R2 lane deposits
    wr(2, 0, 32'hA5A5_0001); wr(2, 1, 32'h5A5A_0002); wr(2, 0, 32'hC0DE_0003);
    rd(2, 0, v); check("R2 route lo", v, 32'hC0DE_0003);
    rd(2, 1, v); check("R2 route hi kept", v, 32'h5A5A_0002);
    wr(1, 0, 32'h100);
    rd(1, 1, v); check("R2 cmp hi kept", v, 32'hFFFF_FFFF);
    wr(1, 1, 32'h0);
    rd(1, 0, v); check("R2 cmp lo kept", v, 32'h100);
    // R3 steering
    wr(0, 0, 32'h000C);            // periodic + enable
    wr(1, 0, 32'h55);
    rd(1, 0, v); check("R3 periodic no setval cmp", v, 32'h100);
    rd(3, 0, v); check("R3 periodic period", v, 32'h55);
    wr(0, 0, 32'h004C);            // + set-value
    wr(1, 0, 32'h200);
    rd(1, 0, v); check("R3 setval cmp", v, 32'h200);
    rd(3, 0, v); check("R3 setval period", v, 32'h200);
    rd(0, 0, v); check("R4 setval cleared", v, 32'h803C);
    // R6 / R8 periodic reload, edge pulse
    glb_en = 1;
    main_cnt = 64'h200;
    @(negedge clk);
    check("R8 edge pulse", irq_out, 1);
    check("R8 status unchanged", irq_sts, 0);
    main_cnt = 64'h201;
    @(negedge clk);
    check("R8 pulse one cycle", irq_out, 0);
    rd(1, 0, v); check("R6 reload", v, 32'h400);
    // R6 zero period
    wr(1, 0, 32'h0);
    rd(3, 0, v); check("R6 period zero", v, 0);
    hit_at(64'h400);
    check("R6 zero-period fires", irq_out, 1);
    rd(1, 0, v); check("R6 zero period keeps cmp", v, 32'h400);
    // R7 gating
    wr(0, 0, 32'h0006); glb_en = 0;
    hit_at(64'h400);
    check("R7 global off", {irq_out, irq_sts}, 0);
    wr(0, 0, 32'h0002); glb_en = 1;
    hit_at(64'h400);
    check("R7 channel off", {irq_out, irq_sts}, 0);
    // R9 level
    wr(0, 0, 32'h0006);
    hit_at(64'h400);
    check("R9 level set", {irq_out, irq_sts}, 2'b11);
    main_cnt = 64'h401;
    repeat (3) @(negedge clk);
    check("R9 level held", {irq_out, irq_sts}, 2'b11);
    sts_clr = 1;
    @(negedge clk);
    sts_clr = 0;
    check("R9 cleared", {irq_out, irq_sts}, 0);
    // R5 32-bit mode
    wr(1, 1, 32'h1234);
    rd(1, 1, v); check("R5 hi before", v, 32'h1234);
    wr(0, 0, 32'h0104);
    rd(1, 1, v); check("R5 truncated", v, 0);
    wr(1, 1, 32'h77);
    rd(1, 1, v); check("R5 hi write ignored", v, 0);
    hit_at(64'h0000_ABCD_0000_0400);
    check("R5 low-half match", irq_out, 1);
    // R10 message
    wr(2, 0, 32'h1111_2222); wr(2, 1, 32'h3333_4444);
    wr(0, 0, 32'h4004);
    hit_at(64'h400);
    check("R10 msg req", msg_req, 1);
    check("R10 msg data", msg_data, 32'h1111_2222);
    check("R10 msg addr", msg_addr, 32'h3333_4444);
    check("R10 no line", irq_out, 0);
    @(negedge clk);
    check("R10 single", msg_req, 0);
    // R11 line routing
    wr(0, 0, 32'h0A04);
    @(negedge clk);
    check("R11 route field", irq_line, 5);
    legacy_en = 1;
    @(negedge clk);
    check("R11 legacy channel 1", irq_line, 8);
    legacy_en = 0;
    @(negedge clk);
    check("R11 back to route", irq_line, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule